// File: doc/BRIEF.md
# Phase-Shifted Dual PWM Generator

This block drives two pulse-width modulated outputs that share one clock, one period value and one duty value. The second output trails the first by a programmable number of clock counts. Each channel has its own up-counter. The counter runs from zero up to the period value and then returns to zero. The output is high from the wrap until the counter reaches the duty value.

Two ways of producing the lag are supported. In head-start mode, the first counter is loaded with the phase value. The second counter starts from zero on the same clock edge. In compare-start mode, the first counter starts from zero and the second counter waits. A one-shot compare on the first counter, against the phase value, releases the second counter. The period, duty, phase and mode are loaded while the block is disabled. Raising the enable starts both channels.

The first channel raises a one-cycle wrap event at the start of each of its periods. A measurement can use it to time the lag of the second output.

Top module: `dual_phase_pwm`

## Requirements
- R1: Each counter counts 0, 1, …, `cfg_period`, then 0 again. Both outputs therefore repeat every `cfg_period`+1 cycles.
- R2: With 0 < duty ≤ period, an output is high while its counter is below the duty value. It is low from the count equal to the duty value up to and including the period count. The high time is therefore exactly duty cycles per period.
- R3: A duty value of 0 keeps both outputs low at all times.
- R4: A duty value greater than the period value keeps both outputs high while running.
- R5: With `cfg_mode`=0 (head-start), the first clock edge with `en` high does the following:
  - It loads the first counter with the phase value.
  - It loads the second counter with 0.
  - It starts both counters.
  - As a result, every edge of `pwm_b` occurs exactly phase cycles after the matching edge of `pwm_a`.
- R6: With `cfg_mode`=1 (compare-start), the first counter starts at 0 and `pwm_b` stays low. On the edge after the first counter equals the phase value, the second counter starts at 0, and this happens only once per enable. The resulting lag is phase+1 cycles.
- R7: `wrap_evt` is high for exactly the one cycle in which the first counter reads 0 after wrapping from the period value. It is not raised for the initial start.
- R8: While `en` is low, both counters are cleared and `pwm_a`, `pwm_b` and `wrap_evt` are low from the next clock edge on.
- R9: `cfg_we` loads period, duty, phase and mode only while `en` is low. A write while running has no effect on either output.
- R10: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both channels |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; a rising level starts both channels |
| cfg_we | input | 1 | Load strobe for the configuration values |
| cfg_mode | input | 1 | 0 = head-start lag, 1 = compare-start lag |
| cfg_period | input | W | Terminal count of both counters |
| cfg_duty | input | W | Count at which an output falls |
| cfg_phase | input | W | Lag in counts, at most the period value |
| pwm_a | output | 1 | Leading PWM output |
| pwm_b | output | 1 | Lagging PWM output |
| wrap_evt | output | 1 | One-cycle pulse at each wrap of the first counter |

## Verification
The bench predicts both outputs and the wrap pulse cycle by cycle and compares them against the design. Each lag mode is run with a nonzero phase, and compare-start is also run with phase zero.

Expected failures, by case:
- **Off-by-one in the head-start preload:** moves `pwm_b` one cycle away from `pwm_a`.
- **Compare-start released on the wrong cycle:** gives a lag other than phase+1.
- **Duty 0 or duty beyond the period:** a design that compared with the wrong relation would emit glitches or a short low pulse.
- **Wrap pulse on the start edge:** a design that raised it there would produce an extra event.
- **Configuration write while running:** a design that accepted it would change the waveform in mid-stream.

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         cfg_we,
  input  logic         cfg_mode,
  input  logic [W-1:0] cfg_period,
  input  logic [W-1:0] cfg_duty,
  input  logic [W-1:0] cfg_phase,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         wrap_evt
);

  logic [W-1:0] period_q, duty_q, phase_q;
  logic         mode_q;
  logic [W-1:0] cnt_a, cnt_b;
  logic         run_a, run_b, wrap_q;

  wire a_last = (cnt_a == period_q);
  wire b_last = (cnt_b == period_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      duty_q   <= '0;
      phase_q  <= '0;
      mode_q   <= 1'b0;
    end else if (cfg_we && !en) begin
      period_q <= cfg_period;
      duty_q   <= cfg_duty;
      phase_q  <= cfg_phase;
      mode_q   <= cfg_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a  <= '0;
      cnt_b  <= '0;
      run_a  <= 1'b0;
      run_b  <= 1'b0;
      wrap_q <= 1'b0;
    end else if (!en) begin
      cnt_a  <= '0;
      cnt_b  <= '0;
      run_a  <= 1'b0;
      run_b  <= 1'b0;
      wrap_q <= 1'b0;
    end else if (!run_a) begin
      run_a  <= 1'b1;
      cnt_a  <= mode_q ? '0 : phase_q;
      cnt_b  <= '0;
      run_b  <= !mode_q;
      wrap_q <= 1'b0;
    end else begin
      cnt_a  <= a_last ? '0 : cnt_a + 1'b1;
      wrap_q <= a_last;
      if (run_b) begin
        cnt_b <= b_last ? '0 : cnt_b + 1'b1;
      end else if (cnt_a == phase_q) begin
        run_b <= 1'b1;
        cnt_b <= '0;
      end
    end
  end

  assign pwm_a    = run_a && (cnt_a < duty_q);
  assign pwm_b    = run_b && (cnt_b < duty_q);
  assign wrap_evt = wrap_q;

endmodule

// File: rtl/dual_phase_pwm_chk.sv
module dual_phase_pwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         pwm_a,
  input logic         pwm_b,
  input logic         wrap_evt,
  input logic         run_a,
  input logic [W-1:0] cnt_a,
  input logic [W-1:0] period_q,
  input logic [W-1:0] duty_q
);

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_a && !pwm_b && !wrap_evt));

  assert_single_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && period_q != '0) |=> !wrap_evt);

  assert_wrap_at_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> (cnt_a == '0));

  assert_zero_duty_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> (!pwm_a && !pwm_b));

  assert_full_duty_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_a && duty_q > period_q) |-> pwm_a);

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(period_q) && $stable(duty_q)));

endmodule

bind dual_phase_pwm dual_phase_pwm_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .pwm_a(pwm_a), .pwm_b(pwm_b),
  .wrap_evt(wrap_evt), .run_a(run_a), .cnt_a(cnt_a),
  .period_q(period_q), .duty_q(duty_q)
);

// File: tb/dual_phase_pwm_tb_top.sv
`timescale 1ns/1ps
module dual_phase_pwm_tb_top;
  localparam int W = 16;

  logic clk = 0, rst_n = 0, en = 0, cfg_we = 0, cfg_mode = 0;
  logic [W-1:0] cfg_period = '0, cfg_duty = '0, cfg_phase = '0;
  logic pwm_a, pwm_b, wrap_evt;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [2:0] q_exp[$];
  string q_tag[$];

  always #2 clk = ~clk;

  dual_phase_pwm #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_period(cfg_period), .cfg_duty(cfg_duty), .cfg_phase(cfg_phase),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .wrap_evt(wrap_evt)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {a,b,wrap} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [2:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, {pwm_a, pwm_b, wrap_evt}, e);
    end
  end

  function automatic logic [2:0] predict(int p, int d, int ph, int mode, int t);
    int ca, cp, cb;
    logic a, b, w;
    ca = ((mode ? 0 : ph) + t) % (p + 1);
    a = (ca < d);
    if (mode == 0) begin
      cb = t % (p + 1);
      b = (cb < d);
    end else if (t >= ph + 1) begin
      cb = (t - ph - 1) % (p + 1);
      b = (cb < d);
    end else b = 1'b0;
    if (t == 0) w = 1'b0;
    else begin
      cp = ((mode ? 0 : ph) + t - 1) % (p + 1);
      w = (cp == p);
    end
    return {a, b, w};
  endfunction

  task automatic run_case(input int p, input int d, input int ph, input int mode,
                          input int n, input string tag, input bit poke);
    @(negedge clk);
    cfg_we = 1; cfg_period = W'(p); cfg_duty = W'(d); cfg_phase = W'(ph); cfg_mode = mode[0];
    @(negedge clk);
    cfg_we = 0; cfg_period = '0; cfg_duty = '0; cfg_phase = '0;
    en = 1;
    @(posedge clk);
    for (int t = 0; t < n; t++) begin
      q_exp.push_back(predict(p, d, ph, mode, t));
      q_tag.push_back(tag);
    end
    if (poke) begin
      repeat (6) @(negedge clk);
      cfg_we = 1; cfg_duty = '0; cfg_period = W'(3); cfg_mode = ~mode[0];
      @(negedge clk);
      cfg_we = 0;
    end
    wait (q_exp.size() == 0);
    @(negedge clk);
    en = 0;
    @(negedge clk);
    check("R8", {pwm_a, pwm_b, wrap_evt}, 3'b000);
    repeat (2) @(negedge clk);
    check("R8", {pwm_a, pwm_b, wrap_evt}, 3'b000);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", {pwm_a, pwm_b, wrap_evt}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    check("R10", {pwm_a, pwm_b, wrap_evt}, 3'b000);

    run_case(9, 5, 2, 0, 40, "R5", 0);
    run_case(15, 8, 4, 0, 50, "R1", 0);
    run_case(9, 5, 2, 1, 40, "R6", 0);
    run_case(7, 3, 0, 1, 30, "R6", 0);
    run_case(7, 7, 3, 0, 30, "R2", 0);
    run_case(9, 0, 3, 0, 30, "R3", 0);
    run_case(9, 12, 3, 1, 30, "R4", 0);
    run_case(4, 2, 1, 0, 25, "R7", 0);
    run_case(11, 6, 3, 0, 40, "R9", 1);
    run_case(11, 6, 3, 0, 30, "R9", 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule